// File: doc/BRIEF.md
# Privilege-Gated Event Counter Bank

A small performance-monitor block holding three 32-bit event counters. Each counter has its own event-type field, which picks one line of an event pulse vector. The counter adds one in every cycle in which that line is high and the counter is enabled. Software does not address the counters directly. A select register chooses one counter slot, and two shared ports (current count, current event type) then reach that slot's counter and type field.

Every access on the register bus carries a privilege flag. Privileged accesses always succeed. A user-mode access to the select, count or event-type registers succeeds only while the user-enable bit is set. The user-enable bit itself can be read in any mode but written only in privileged mode. The counter-enable control register stays privileged-only whatever the user-enable bit holds. A refused access reads zero, changes nothing and raises an error flag.

Bus map (addr_i): 0 = control (bits[2:0] are the counter enables), 1 = select, 2 = current count, 3 = current event type, 4 = user enable (bit 0). Addresses 5 to 7 read zero, ignore writes and never raise an error. A request updates state at the clock edge where req_i is high. rdata_o and err_o are registered and belong to the request of the previous cycle. Both are zero in every cycle that follows no request.

Top module: `pmu_bank`

## Requirements
- R1: Three 32-bit counters are written and read back through address 2 at the slot named by the select register (address 1). A read returns the value held before that cycle's increment.
- R2: A counter adds 1 in each cycle where it is enabled and events_i[type] is 1, with type taken from its event-type field (address 3, 3 bits). It wraps from 0xFFFFFFFF to 0.
- R3: The select value decides which counter and which event-type field addresses 2 and 3 reach. With a select value above 2, reads of addresses 2 and 3 return 0 and writes to them change no counter and no type field.
- R4: Privileged accesses to every address are always allowed. User accesses to addresses 1, 2 and 3 are allowed only while the user-enable bit is 1.
- R5: The user-enable bit (address 4, bit 0) can be read in both modes and written only in privileged mode. A user write to it is refused.
- R6: A refused access returns 0, leaves every register unchanged and sets err_o for exactly the one cycle after the request. Allowed accesses never set err_o.
- R7: The control register (address 0) refuses every user access, even while the user-enable bit is 1.
- R8: A software write to a counter in the same cycle as its event wins: the counter takes the written value.
- R9: After reset all counters, type fields, enables, select and user enable are 0. A counter whose enable bit is 0 holds its value whatever the events do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| priv_i | input | 1 | 1 = privileged access, 0 = user access |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| events_i | input | 8 | Event pulse vector |
| rdata_o | output | 32 | Read data of the previous cycle's request |
| err_o | output | 1 | Previous cycle's request was refused |

## Verification
The bench drives a counter write in the same cycle as that counter's event. A design that lets the increment win shows a value one too high. It steers the select register past the last slot and then reads and writes there. A design that indexes unguarded would alias a real counter or corrupt one. It sends user accesses with the user-enable bit clear and set, including writes to the enable bit itself and to the control register. A permission decoder that is too loose shows up as a changed register or a missing error pulse, and one that is too strict shows up as a spurious error. It also loads 0xFFFFFFFF and pulses the event, which exposes any wrong wrap behaviour.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_SEL  = 3'd1,
    A_CNT  = 3'd2,
    A_EVT  = 3'd3,
    A_UEN  = 3'd4
  } pmu_addr_e;
endpackage

// File: rtl/pmu_access.sv
module pmu_access
  import pmu_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              uen_i,
  output logic              deny_o,
  output logic              rd_o,
  output logic              wr_ctrl_o,
  output logic              wr_sel_o,
  output logic              wr_cnt_o,
  output logic              wr_evt_o,
  output logic              wr_uen_o
);
  logic ok;
  logic wr;

  always_comb begin
    case (pmu_addr_e'(addr_i))
      A_CTRL:              ok = priv_i;
      A_SEL, A_CNT, A_EVT: ok = priv_i | uen_i;
      A_UEN:               ok = priv_i | ~we_i;
      default:             ok = 1'b1;
    endcase
  end

  assign deny_o    = req_i & ~ok;
  assign rd_o      = req_i & ok & ~we_i;
  assign wr        = req_i & ok & we_i;
  assign wr_ctrl_o = wr & (addr_i == A_CTRL);
  assign wr_sel_o  = wr & (addr_i == A_SEL);
  assign wr_cnt_o  = wr & (addr_i == A_CNT);
  assign wr_evt_o  = wr & (addr_i == A_EVT);
  assign wr_uen_o  = wr & (addr_i == A_UEN);

  always_comb begin
    AST_CTRL_PRIV_ONLY: assert (!(wr_ctrl_o && !priv_i)); // R7
    AST_DENY_NO_WRITE: assert (!(deny_o && (wr_sel_o || wr_cnt_o || wr_evt_o || wr_uen_o || wr_ctrl_o))); // R6
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned NUM_EVENTS = 8,
  localparam int unsigned EVT_W     = $clog2(NUM_EVENTS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  load_i,
  input  logic [CNT_W-1:0]      load_val_i,
  input  logic                  evt_wr_i,
  input  logic [EVT_W-1:0]      evt_val_i,
  input  logic [NUM_EVENTS-1:0] events_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [EVT_W-1:0]      evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [EVT_W-1:0] evt_q;
  logic             hit;

  assign hit = en_i & events_i[evt_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      evt_q <= '0;
    end else begin
      if (load_i)   cnt_q <= load_val_i;  // software write wins
      else if (hit) cnt_q <= cnt_q + CNT_W'(1);
      if (evt_wr_i) evt_q <= evt_val_i;
    end
  end

  assign cnt_o = cnt_q;
  assign evt_o = evt_q;

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i)); // R8
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load_i) && !$stable(cnt_q)) |-> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2
  AST_DISABLED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/pmu_bank.sv
module pmu_bank
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_CNT    = 3,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned NUM_EVENTS = 8,
  parameter int unsigned SEL_W      = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic                  priv_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [CNT_W-1:0]      wdata_i,
  input  logic [NUM_EVENTS-1:0] events_i,
  output logic [CNT_W-1:0]      rdata_o,
  output logic                  err_o
);
  localparam int unsigned EVT_W = $clog2(NUM_EVENTS);

  logic [NUM_CNT-1:0] en_q;
  logic [SEL_W-1:0]   sel_q;
  logic               uen_q;
  logic               deny, rd, wr_ctrl, wr_sel, wr_cnt, wr_evt, wr_uen;
  logic [CNT_W-1:0]   cnt_arr [NUM_CNT];
  logic [EVT_W-1:0]   evt_arr [NUM_CNT];
  logic [CNT_W-1:0]   cur_cnt, rd_val;
  logic [EVT_W-1:0]   cur_evt;

  pmu_access u_access (
    .req_i     (req_i),
    .we_i      (we_i),
    .priv_i    (priv_i),
    .addr_i    (addr_i),
    .uen_i     (uen_q),
    .deny_o    (deny),
    .rd_o      (rd),
    .wr_ctrl_o (wr_ctrl),
    .wr_sel_o  (wr_sel),
    .wr_cnt_o  (wr_cnt),
    .wr_evt_o  (wr_evt),
    .wr_uen_o  (wr_uen)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic slot;
    assign slot = (sel_q == SEL_W'(i));
    pmu_counter #(
      .CNT_W      (CNT_W),
      .NUM_EVENTS (NUM_EVENTS)
    ) u_counter (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_q[i]),
      .load_i     (wr_cnt & slot),
      .load_val_i (wdata_i),
      .evt_wr_i   (wr_evt & slot),
      .evt_val_i  (wdata_i[EVT_W-1:0]),
      .events_i   (events_i),
      .cnt_o      (cnt_arr[i]),
      .evt_o      (evt_arr[i])
    );
  end

  // out-of-range select matches no slot: reads 0
  always_comb begin
    cur_cnt = '0;
    cur_evt = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (sel_q == SEL_W'(i)) begin
        cur_cnt = cnt_arr[i];
        cur_evt = evt_arr[i];
      end
    end
  end

  always_comb begin
    case (pmu_addr_e'(addr_i))
      A_CTRL:  rd_val = CNT_W'(en_q);
      A_SEL:   rd_val = CNT_W'(sel_q);
      A_CNT:   rd_val = cur_cnt;
      A_EVT:   rd_val = CNT_W'(cur_evt);
      A_UEN:   rd_val = CNT_W'(uen_q);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      sel_q   <= '0;
      uen_q   <= 1'b0;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (wr_ctrl) en_q  <= wdata_i[NUM_CNT-1:0];
      if (wr_sel)  sel_q <= wdata_i[SEL_W-1:0];
      if (wr_uen)  uen_q <= wdata_i[0];
      rdata_o <= rd ? rd_val : '0;
      err_o   <= deny;
    end
  end

  AST_ERR_FROM_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i && !priv_i)); // R6
  AST_ERR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0); // R6
  AST_UEN_PRIV_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(uen_q) |-> $past(req_i && we_i && priv_i && addr_i == A_UEN)); // R5
  AST_CTRL_STABLE_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !priv_i) |=> $stable(en_q)); // R7
  AST_USER_NEEDS_UEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !priv_i && !uen_q && (addr_i == A_SEL || addr_i == A_CNT || addr_i == A_EVT)) |=> err_o); // R4
endmodule

// File: tb/sim_pmu_bank.sv
module sim_pmu_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, priv = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  ev = '0;
  logic [31:0] rdata;
  logic        err;

  int checks = 0, failures = 0;
  string tag = "R9";
  bit done = 0;

  always #2 clk = ~clk;

  pmu_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .priv_i(priv),
    .addr_i(addr), .wdata_i(wdata), .events_i(ev), .rdata_o(rdata), .err_o(err)
  );

  // behavioural reference
  logic [31:0] m_cnt [3];
  logic [2:0]  m_evt [3];
  logic [2:0]  m_en;
  logic [4:0]  m_sel;
  logic        m_uen;
  logic [31:0] exp_rdata;
  logic        exp_err;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {29'b0, m_en};
      3'd1: return {27'b0, m_sel};
      3'd2: return (m_sel < 3) ? m_cnt[m_sel] : 32'h0;
      3'd3: return (m_sel < 3) ? {29'b0, m_evt[m_sel]} : 32'h0;
      3'd4: return {31'b0, m_uen};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_evt[i] = 0; end
      m_en = 0; m_sel = 0; m_uen = 0; exp_rdata = 0; exp_err = 0;
    end else begin
      bit ok;
      bit [2:0] inc;
      logic [31:0] nr;
      if (addr == 3'd0) ok = priv;
      else if (addr >= 3'd1 && addr <= 3'd3) ok = priv || m_uen;
      else if (addr == 3'd4) ok = priv || !we;
      else ok = 1;
      nr = 0;
      if (req && ok && !we) nr = m_read(addr);
      for (int i = 0; i < 3; i++) inc[i] = m_en[i] && ev[m_evt[i]];
      for (int i = 0; i < 3; i++) begin
        if (req && ok && we && addr == 3'd2 && m_sel == i) m_cnt[i] = wdata;
        else if (inc[i]) m_cnt[i] = m_cnt[i] + 1;
      end
      if (req && ok && we) begin
        case (addr)
          3'd0: m_en = wdata[2:0];
          3'd1: m_sel = wdata[4:0];
          3'd3: if (m_sel < 3) m_evt[m_sel] = wdata[2:0];
          3'd4: m_uen = wdata[0];
          default: ;
        endcase
      end
      exp_rdata = nr;
      exp_err = req && !ok;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rdata !== exp_rdata || err !== exp_err) begin
        failures++;
        $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                 tag, rdata, err, exp_rdata, exp_err);
      end
    end
  end

  task automatic op(input bit w, input bit p, input logic [2:0] a,
                    input logic [31:0] d, input logic [7:0] e = 8'h0);
    req = 1; we = w; priv = p; addr = a; wdata = d; ev = e;
    @(negedge clk);
    req = 0; we = 0; ev = 0;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [7:0] e = 8'h0);
    ev = e;
    repeat (n) @(negedge clk);
    ev = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset values
    tag = "R9";
    idle(2);
    for (int a = 0; a < 8; a++) op(0, 1, a[2:0], 0);
    // R1: write and read back each slot
    tag = "R1";
    op(1, 1, 3'd1, 0); op(1, 1, 3'd2, 32'h0000_AAAA);
    op(1, 1, 3'd1, 1); op(1, 1, 3'd2, 32'h1234_5678);
    op(1, 1, 3'd1, 2); op(1, 1, 3'd2, 32'h0000_0055);
    for (int s = 0; s < 3; s++) begin op(1, 1, 3'd1, s); op(0, 1, 3'd2, 0); end
    // R3: select beyond range
    tag = "R3";
    op(1, 1, 3'd1, 3); op(1, 1, 3'd2, 7); op(1, 1, 3'd3, 5);
    op(0, 1, 3'd2, 0); op(0, 1, 3'd3, 0);
    op(1, 1, 3'd1, 31); op(1, 1, 3'd2, 9); op(0, 1, 3'd2, 0);
    for (int s = 0; s < 3; s++) begin op(1, 1, 3'd1, s); op(0, 1, 3'd2, 0); op(0, 1, 3'd3, 0); end
    // R2: counting on chosen events
    tag = "R2";
    op(1, 1, 3'd1, 0); op(1, 1, 3'd3, 2);
    op(1, 1, 3'd1, 1); op(1, 1, 3'd3, 5);
    op(1, 1, 3'd0, 3'b011);
    idle(3, 8'h04); idle(2, 8'h20); idle(4, 8'h24); idle(2, 8'hDB);
    op(0, 1, 3'd2, 0, 8'h20);
    op(1, 1, 3'd1, 0); op(0, 1, 3'd2, 0); op(0, 1, 3'd3, 0);
    // R2: wrap
    op(1, 1, 3'd1, 2); op(1, 1, 3'd2, 32'hFFFF_FFFF); op(1, 1, 3'd0, 3'b111);
    idle(1, 8'h01); op(0, 1, 3'd2, 0);
    // R8: write beats event
    tag = "R8";
    op(1, 1, 3'd2, 32'h0000_0100, 8'h01); op(0, 1, 3'd2, 0);
    op(1, 1, 3'd1, 0); op(1, 1, 3'd2, 32'h0000_0010, 8'h04); op(0, 1, 3'd2, 0);
    // R4/R6: user denied while enable bit clear
    tag = "R6";
    op(0, 0, 3'd2, 0); op(1, 0, 3'd2, 32'hDEAD); op(1, 0, 3'd1, 2);
    op(1, 0, 3'd3, 7); op(0, 0, 3'd1, 0);
    op(0, 1, 3'd1, 0); op(0, 1, 3'd2, 0); op(0, 1, 3'd3, 0);
    op(0, 0, 3'd6, 0);
    // R5: user reads enable bit, cannot write it
    tag = "R5";
    op(0, 0, 3'd4, 0); op(1, 0, 3'd4, 1); op(0, 1, 3'd4, 0);
    op(1, 1, 3'd4, 1); op(0, 0, 3'd4, 0); op(1, 0, 3'd4, 0); op(0, 0, 3'd4, 0);
    // R4: user allowed now
    tag = "R4";
    op(0, 0, 3'd2, 0); op(1, 0, 3'd1, 1); op(0, 0, 3'd2, 0);
    op(1, 0, 3'd2, 32'h0BAD_F00D); op(0, 0, 3'd2, 0); op(1, 0, 3'd3, 6); op(0, 0, 3'd3, 0);
    // R7: control stays privileged
    tag = "R7";
    op(0, 0, 3'd0, 0); op(1, 0, 3'd0, 0); op(0, 1, 3'd0, 0);
    idle(2, 8'h45); op(0, 0, 3'd2, 0);
    // R9: disabled counter holds
    tag = "R9";
    op(1, 1, 3'd0, 3'b101);
    idle(3, 8'hFF); op(0, 1, 3'd2, 0);
    op(1, 1, 3'd1, 0); op(0, 1, 3'd2, 0);
    op(1, 1, 3'd0, 0); idle(3, 8'hFF);
    op(0, 1, 3'd2, 0); op(1, 1, 3'd1, 2); op(0, 1, 3'd2, 0);
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule